// File: doc/BRIEF.md
# Reformatting Block Move Engine

This engine copies a run of 36-bit memory words from one address range to another and rearranges the bits of every word in flight. It has two directions. In one, a word holding four packed 8-bit bytes becomes a word holding two 16-bit bus halfwords, with the bytes of each halfword swapped and a two-bit pad ahead of each halfword. In the other direction, the engine packs the bus layout back into four consecutive bytes.

A start command carries a 9-bit opcode, a 36-bit pointer value and an 18-bit end address. The pointer value holds the source address in its upper half and the destination address in its lower half. The engine then walks the range through a single request/acknowledge memory port, one read and one write per word. At each word boundary it can stop for an interrupt request, and it stops at once on a memory fault. When it stops it reports why, together with the current pointer value. Starting again with that pointer resumes the move at the next word.

Top module: `blkmove_xform`

## Requirements
- R1: With opcode 716 (octal), each written word is laid out as follows (vector bit 35 is the most significant): bits 35:34 and 17:16 are zero; bits 33:26 hold source bits 27:20; bits 25:18 hold source bits 35:28; bits 15:8 hold source bits 11:4; bits 7:0 hold source bits 19:12.
- R2: With opcode 717 (octal), each written word is laid out as follows: bits 35:28 hold source bits 25:18; bits 27:20 hold source bits 33:26; bits 19:12 hold source bits 7:0; bits 11:4 hold source bits 15:8; bits 3:0 are zero.
- R3: A start with any other opcode, or a start that arrives while a move is running, is ignored. No memory request is made, `busy_o` stays as it was, and no `done_o` pulse follows.
- R4: For each word the engine reads the source address (pointer bits 35:18) and then writes the destination address (pointer bits 17:0). It makes no other memory access. It always moves at least one word, and it finishes after the word written to `end_i`. On finishing it pulses `done_o` for one cycle and sets `stat_o` to 1.
- R5: Each completed word adds one to each pointer half, each half wrapping at 18 bits. `ptr_o` shows the pointer at all times and is zero after reset. `stat_o` is 0 from reset until the first stop.
- R6: When `irq_i` is high at the cycle in which a word's write completes, and that word is not the last one, the engine stops before the next read. It pulses `done_o`, sets `stat_o` to 2, and `ptr_o` then addresses the next word. A new start with that pointer and the same end address completes the rest of the move.
- R7: An access that is acknowledged with `mem_err_i` high ends the move. That word is not written, the engine pulses `done_o` and sets `stat_o` to 3, and `ptr_o` stays at the failing word.
- R8: `mem_req_o` stays high, and `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay stable, until `mem_ack_i` arrives, however many wait cycles the memory inserts.
- R9: A destination that overlaps the source gets no special handling. Every read returns current memory contents, so with the destination one word above the source each word is the transform of the word just written.
- R10: Converting a word with 716 and then converting the result with 717 gives back source bits 35:4, with bits 3:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command strobe |
| opcode_i | input | 9 | Direction opcode, 716 or 717 octal |
| ptr_i | input | 36 | Start pointer: source in upper half, destination in lower half |
| end_i | input | 18 | Destination address of the last word |
| irq_i | input | 1 | Interrupt request, sampled at word boundaries |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 18 | Memory word address |
| mem_wdata_o | output | 36 | Write data |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access faulted, valid with the acknowledge |
| mem_rdata_i | input | 36 | Read data, valid with the acknowledge |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle pulse when the engine stops |
| stat_o | output | 2 | Stop reason: 0 none, 1 complete, 2 interrupted, 3 fault |
| ptr_o | output | 36 | Current pointer value |

## Verification
An error in the pointer or in the word counter shows up at the next memory request, as a wrong address or an access made after the end address. A scoreboard that matches every write by address and value catches it within one word. A bad transform shows up in the first written word, and a lost interrupt or fault decision shows up as an extra write and a wrong `stat_o` in the cycle after the access completes. Interrupted moves, faults on reads and on writes, and overlapping ranges are each followed through to the final pointer value, and then through the contents of the untouched memory word.

// File: rtl/wmx_pkg.sv
package wmx_pkg;
  localparam int WORD_W = 36;
  localparam int HALF_W = 18;
  localparam int BYTE_W = 8;
  localparam int OPC_W  = 9;
  localparam int PAD_W  = 2;
  localparam int TAIL_W = WORD_W - 4 * BYTE_W;

  localparam logic [OPC_W-1:0] OPC_TO_BUS  = 9'o716;
  localparam logic [OPC_W-1:0] OPC_TO_PACK = 9'o717;

  typedef enum logic [1:0] {
    STOP_NONE  = 2'd0,
    STOP_DONE  = 2'd1,
    STOP_IRQ   = 2'd2,
    STOP_FAULT = 2'd3
  } stop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } st_e;

  // Byte n (1..4) of the packed layout, counted from the most significant end.
  function automatic logic [BYTE_W-1:0] pk_byte(input logic [WORD_W-1:0] w, input int n);
    return w[WORD_W-1-(n-1)*BYTE_W -: BYTE_W];
  endfunction

  // Packed four-byte word -> two byte-swapped halfwords, each with a zero pad.
  function automatic logic [WORD_W-1:0] to_bus(input logic [WORD_W-1:0] w);
    return {{PAD_W{1'b0}}, pk_byte(w, 2), pk_byte(w, 1),
            {PAD_W{1'b0}}, pk_byte(w, 4), pk_byte(w, 3)};
  endfunction

  // Bus halfword word -> packed four bytes, zero tail.
  function automatic logic [WORD_W-1:0] to_pack(input logic [WORD_W-1:0] w);
    logic [BYTE_W-1:0] b1, b2, b3, b4;
    b2 = w[WORD_W-1-PAD_W -: BYTE_W];
    b1 = w[WORD_W-1-PAD_W-BYTE_W -: BYTE_W];
    b4 = w[HALF_W-1-PAD_W -: BYTE_W];
    b3 = w[BYTE_W-1:0];
    return {b1, b2, b3, b4, {TAIL_W{1'b0}}};
  endfunction

  function automatic logic opc_valid(input logic [OPC_W-1:0] op);
    return (op == OPC_TO_BUS) || (op == OPC_TO_PACK);
  endfunction
endpackage

// File: rtl/wmx_permute.sv
module wmx_permute
  import wmx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         dir_bus_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] bus_w;
  logic [W-1:0] pack_w;

  assign bus_w  = to_bus(word_i);
  assign pack_w = to_pack(word_i);
  assign word_o = dir_bus_i ? bus_w : pack_w;

  // Composing the two directions must give back the 32 data bits.
  always_comb begin
    assert_roundtrip_R10: assert (to_pack(bus_w) == {word_i[W-1:TAIL_W], {TAIL_W{1'b0}}})
      else $error("round trip lost data");
  end
endmodule

// File: rtl/wmx_ptr.sv
module wmx_ptr
  import wmx_pkg::*;
#(
  parameter int HW = HALF_W,
  localparam int PW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  input  logic          step_i,
  output logic [HW-1:0] src_o,
  output logic [HW-1:0] dst_o,
  output logic [PW-1:0] ptr_o
);
  logic [HW-1:0] src_q, dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (load_i) begin
      src_q <= load_val_i[PW-1:HW];
      dst_q <= load_val_i[HW-1:0];
    end else if (step_i) begin
      src_q <= src_q + HW'(1);
      dst_q <= dst_q + HW'(1);
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign ptr_o = {src_q, dst_q};

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (src_o == $past(src_o) + HW'(1)) && (dst_o == $past(dst_o) + HW'(1)))
    else $error("pointer step wrong");

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(ptr_o))
    else $error("pointer moved without a step");
endmodule

// File: rtl/wmx_ctrl.sv
module wmx_ctrl
  import wmx_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [HW-1:0]    end_i,
  input  logic [HW-1:0]    dst_i,
  input  logic             irq_i,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  output st_e              state_o,
  output logic             dir_bus_o,
  output logic             load_o,
  output logic             step_o,
  output logic             rd_ok_o,
  output logic             done_o,
  output stop_e            stat_o
);
  st_e           st_q, st_d;
  stop_e         stat_q, stat_d;
  logic          done_q, done_d;
  logic          dir_q;
  logic [HW-1:0] end_q;

  // Named events for the assertions and for the datapath.
  logic accept, rd_fault, wr_ok, wr_fault, last_word;
  assign accept    = (st_q == ST_IDLE) && start_i && opc_valid(opcode_i);
  assign rd_ok_o   = (st_q == ST_RD) && mem_ack_i && !mem_err_i;
  assign rd_fault  = (st_q == ST_RD) && mem_ack_i && mem_err_i;
  assign wr_ok     = (st_q == ST_WR) && mem_ack_i && !mem_err_i;
  assign wr_fault  = (st_q == ST_WR) && mem_ack_i && mem_err_i;
  assign last_word = (dst_i == end_q);

  always_comb begin
    st_d   = st_q;
    stat_d = stat_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_RD;
        stat_d = STOP_NONE;
      end
      ST_RD: if (rd_fault) begin
        st_d   = ST_IDLE;
        stat_d = STOP_FAULT;
        done_d = 1'b1;
      end else if (rd_ok_o) begin
        st_d = ST_WR;
      end
      ST_WR: if (wr_fault) begin
        st_d   = ST_IDLE;
        stat_d = STOP_FAULT;
        done_d = 1'b1;
      end else if (wr_ok) begin
        if (last_word) begin
          st_d   = ST_IDLE;
          stat_d = STOP_DONE;
          done_d = 1'b1;
        end else if (irq_i) begin
          st_d   = ST_IDLE;
          stat_d = STOP_IRQ;
          done_d = 1'b1;
        end else begin
          st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stat_q <= STOP_NONE;
      done_q <= 1'b0;
      dir_q  <= 1'b0;
      end_q  <= '0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      done_q <= done_d;
      if (accept) begin
        dir_q <= (opcode_i == OPC_TO_BUS);
        end_q <= end_i;
      end
    end
  end

  assign state_o   = st_q;
  assign dir_bus_o = dir_q;
  assign load_o    = accept;
  assign step_o    = wr_ok;
  assign done_o    = done_q;
  assign stat_o    = stat_q;

  assert_badop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && !opc_valid(opcode_i)) |=> (st_q == ST_IDLE))
    else $error("unknown opcode started a move");

  assert_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !mem_ack_i) |=> (st_q == $past(st_q)))
    else $error("access left without acknowledge");

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok_o |=> (st_q == ST_WR))
    else $error("good read not followed by write");

  assert_fault_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fault || wr_fault) |=> (st_q == ST_IDLE && stat_q == STOP_FAULT && done_q))
    else $error("fault did not stop the move");

  assert_irq_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !last_word && irq_i) |=> (st_q == ST_IDLE && stat_q == STOP_IRQ))
    else $error("interrupt not taken at word boundary");

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE))
    else $error("done while busy");
endmodule

// File: rtl/blkmove_xform.sv
module blkmove_xform
  import wmx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [2*HALF_W-1:0] ptr_i,
  input  logic [HALF_W-1:0]   end_i,
  input  logic                irq_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [HALF_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic                mem_err_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          stat_o,
  output logic [2*HALF_W-1:0] ptr_o
);
  st_e                 state;
  stop_e               stat;
  logic                dir_bus, load, step, rd_ok;
  logic [HALF_W-1:0]   src, dst;
  logic [WORD_W-1:0]   xf_word, xf_q;

  wmx_ctrl #(.HW(HALF_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .opcode_i  (opcode_i),
    .end_i     (end_i),
    .dst_i     (dst),
    .irq_i     (irq_i),
    .mem_ack_i (mem_ack_i),
    .mem_err_i (mem_err_i),
    .state_o   (state),
    .dir_bus_o (dir_bus),
    .load_o    (load),
    .step_o    (step),
    .rd_ok_o   (rd_ok),
    .done_o    (done_o),
    .stat_o    (stat)
  );

  wmx_ptr #(.HW(HALF_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (ptr_i),
    .step_i     (step),
    .src_o      (src),
    .dst_o      (dst),
    .ptr_o      (ptr_o)
  );

  wmx_permute #(.W(WORD_W)) u_perm (
    .dir_bus_i (dir_bus),
    .word_i    (mem_rdata_i),
    .word_o    (xf_word)
  );

  // One holding register: the transformed word waits here for its write.
  always_ff @(posedge clk) begin
    if (!rst_n)     xf_q <= '0;
    else if (rd_ok) xf_q <= xf_word;
  end

  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state == ST_WR);
  assign mem_addr_o  = mem_we_o ? dst : src;
  assign mem_wdata_o = xf_q;
  assign stat_o      = stat;

  assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o)))
    else $error("memory port changed during wait");

  assert_bus_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && dir_bus) |-> (mem_wdata_o[35:34] == 2'b00 && mem_wdata_o[17:16] == 2'b00))
    else $error("bus pad bits not zero");

  assert_pack_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && !dir_bus) |-> (mem_wdata_o[TAIL_W-1:0] == '0))
    else $error("packed tail bits not zero");

  assert_fault_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ack_i && mem_err_i) |=> $stable(ptr_o))
    else $error("pointer moved on fault");
endmodule

// File: tb/blkmove_xform_tb.sv
module blkmove_xform_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [8:0]  opcode_i = '0;
  logic [35:0] ptr_i = '0;
  logic [17:0] end_i = '0;
  logic        irq_i = 1'b0;
  logic        mem_req_o, mem_we_o;
  logic [17:0] mem_addr_o;
  logic [35:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic [35:0] mem_rdata_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  stat_o;
  logic [35:0] ptr_o;

  always #2 clk = ~clk;  // 250 MHz

  blkmove_xform u_dut (.*);

  int checks = 0;
  int fails  = 0;
  int nwrites = 0;
  int naccess = 0;

  logic [35:0] mem    [64];
  logic [35:0] shadow [64];
  logic [53:0] exp_q  [$];

  int          wait_cyc = 0;
  int          wcnt = 0;
  logic        err_en = 1'b0;
  logic        err_we = 1'b0;
  logic [17:0] err_addr = '0;
  logic [17:0] cap_addr = '0;
  string       cur_tag = "R1";

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench's own statement of the two layouts, by byte list.
  function automatic logic [35:0] b_bus(input logic [35:0] w);
    logic [7:0] b [4];
    for (int i = 0; i < 4; i++) b[i] = w[35 - 8*i -: 8];
    return {2'b00, b[1], b[0], 2'b00, b[3], b[2]};
  endfunction

  function automatic logic [35:0] b_pack(input logic [35:0] w);
    logic [7:0] hi_lo, hi_hi, lo_lo, lo_hi;
    hi_hi = w[33:26]; hi_lo = w[25:18]; lo_hi = w[15:8]; lo_lo = w[7:0];
    return {hi_lo, hi_hi, lo_lo, lo_hi, 4'h0};
  endfunction

  // Driver side of the scoreboard: predict n words and queue them.
  task automatic plan(input logic [8:0] op, input int src, input int dst, input int n);
    for (int k = 0; k < n; k++) begin
      logic [35:0] d;
      d = (op == 9'o716) ? b_bus(shadow[(src + k) % 64]) : b_pack(shadow[(src + k) % 64]);
      shadow[(dst + k) % 64] = d;
      exp_q.push_back({18'(dst + k), d});
    end
  endtask

  // Memory model plus monitor.
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      mem_err_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt == 0) cap_addr = mem_addr_o;
      if (wcnt >= wait_cyc) begin
        logic f;
        check(mem_addr_o == cap_addr, "R8 address held", 36'(mem_addr_o), 36'(cap_addr));
        f = err_en && (mem_addr_o == err_addr) && (mem_we_o == err_we);
        mem_ack_i = 1'b1;
        mem_err_i = f;
        naccess++;
        if (!mem_we_o) mem_rdata_i = mem[mem_addr_o[5:0]];
        else if (!f) begin
          logic [53:0] e;
          nwrites++;
          mem[mem_addr_o[5:0]] = mem_wdata_o;
          if (exp_q.size() == 0) begin
            check(1'b0, {cur_tag, " unexpected write"}, mem_wdata_o, 36'h0);
          end else begin
            e = exp_q.pop_front();
            check(mem_addr_o == e[53:36], {cur_tag, " write address"}, 36'(mem_addr_o), 36'(e[53:36]));
            check(mem_wdata_o == e[35:0], {cur_tag, " write data"}, mem_wdata_o, e[35:0]);
          end
        end
      end else wcnt++;
    end
  end

  task automatic go(input logic [8:0] op, input logic [35:0] p, input logic [17:0] e);
    @(negedge clk);
    start_i = 1'b1; opcode_i = op; ptr_i = p; end_i = e;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!done_o) check(1'b0, {cur_tag, " done timeout"}, 36'h0, 36'h1);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 36'h9_1357_9BDF ^ (36'(i) * 36'd40503) ^ (36'(i) << 29);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busy_o && !mem_req_o && !done_o, "reset outputs idle", 36'(busy_o), 36'h0);
    check(stat_o == 2'd0, "R5 reset status", 36'(stat_o), 36'h0);
    check(ptr_o == 36'h0, "R5 reset pointer", ptr_o, 36'h0);
    rst_n = 1'b1;

    // R1 and R4: four words to bus layout, no wait states
    cur_tag = "R1";
    plan(9'o716, 0, 16, 4);
    go(9'o716, {18'd0, 18'd16}, 18'd19);
    wait_done();
    check(stat_o == 2'd1, "R4 complete status", 36'(stat_o), 36'h1);
    check(ptr_o == {18'd4, 18'd20}, "R5 final pointer", ptr_o, {18'd4, 18'd20});
    check(naccess == 8, "R4 one read one write per word", 36'(naccess), 36'd8);
    check(exp_q.size() == 0, "R4 all words written", 36'(exp_q.size()), 36'h0);

    // R2 with wait states (R8)
    cur_tag = "R2";
    wait_cyc = 3;
    plan(9'o717, 16, 24, 4);
    go(9'o717, {18'd16, 18'd24}, 18'd27);
    wait_done();
    check(stat_o == 2'd1 && exp_q.size() == 0, "R2 completed with waits", 36'(stat_o), 36'h1);
    wait_cyc = 0;

    // R10: pack(bus(x)) gives back the data bits of the originals
    cur_tag = "R10";
    for (int k = 0; k < 4; k++)
      check(mem[24 + k] == {mem[k][35:4], 4'h0}, "R10 round trip", mem[24 + k], {mem[k][35:4], 4'h0});

    // R4: single word where destination equals end
    cur_tag = "R4";
    plan(9'o716, 5, 30, 1);
    go(9'o716, {18'd5, 18'd30}, 18'd30);
    wait_done();
    check(ptr_o == {18'd6, 18'd31}, "R4 single word pointer", ptr_o, {18'd6, 18'd31});

    // R3: unknown opcode ignored
    cur_tag = "R3";
    naccess = 0;
    go(9'o715, {18'd0, 18'd40}, 18'd41);
    repeat (20) @(negedge clk);
    check(!busy_o && naccess == 0 && !done_o, "R3 bad opcode ignored", 36'(naccess), 36'h0);
    check(ptr_o == {18'd6, 18'd31}, "R3 pointer untouched", ptr_o, {18'd6, 18'd31});

    // R6: interrupt after first word, then resume
    cur_tag = "R6";
    irq_i = 1'b1;
    plan(9'o716, 32, 40, 4);
    go(9'o716, {18'd32, 18'd40}, 18'd43);
    wait_done();
    check(stat_o == 2'd2, "R6 interrupted status", 36'(stat_o), 36'h2);
    check(ptr_o == {18'd33, 18'd41}, "R6 next word pointer", ptr_o, {18'd33, 18'd41});
    check(exp_q.size() == 3, "R6 one word before stop", 36'(exp_q.size()), 36'h3);
    irq_i = 1'b0;
    go(9'o716, ptr_o, 18'd43);
    wait_done();
    check(stat_o == 2'd1 && exp_q.size() == 0, "R6 resume completes", 36'(exp_q.size()), 36'h0);
    check(ptr_o == {18'd36, 18'd44}, "R6 final pointer", ptr_o, {18'd36, 18'd44});

    // R3: start while busy ignored (new pointer must not load)
    cur_tag = "R3";
    wait_cyc = 2;
    plan(9'o717, 0, 48, 3);
    go(9'o717, {18'd0, 18'd48}, 18'd50);
    go(9'o716, {18'd10, 18'd60}, 18'd60);
    wait_done();
    check(stat_o == 2'd1 && ptr_o == {18'd3, 18'd51}, "R3 start during move ignored", ptr_o, {18'd3, 18'd51});
    wait_cyc = 0;

    // R7: read fault on third word
    cur_tag = "R7";
    err_en = 1'b1; err_we = 1'b0; err_addr = 18'd2;
    plan(9'o716, 0, 52, 2);
    go(9'o716, {18'd0, 18'd52}, 18'd55);
    wait_done();
    check(stat_o == 2'd3, "R7 read fault status", 36'(stat_o), 36'h3);
    check(ptr_o == {18'd2, 18'd54}, "R7 pointer at failing word", ptr_o, {18'd2, 18'd54});
    check(mem[54] == shadow[54], "R7 failing word unwritten", mem[54], shadow[54]);

    // R7: write fault on second word
    err_we = 1'b1; err_addr = 18'd57;
    plan(9'o717, 4, 56, 1);
    go(9'o717, {18'd4, 18'd56}, 18'd59);
    wait_done();
    check(stat_o == 2'd3 && exp_q.size() == 0, "R7 write fault status", 36'(stat_o), 36'h3);
    check(ptr_o == {18'd5, 18'd57}, "R7 pointer on write fault", ptr_o, {18'd5, 18'd57});
    check(mem[57] == shadow[57], "R7 faulted write absent", mem[57], shadow[57]);
    err_en = 1'b0;

    // R9: destination one above source, chained transform
    cur_tag = "R9";
    plan(9'o716, 8, 9, 3);
    go(9'o716, {18'd8, 18'd9}, 18'd11);
    wait_done();
    check(mem[11] == b_bus(b_bus(b_bus(mem[8]))), "R9 overlap chains", mem[11], b_bus(b_bus(b_bus(mem[8]))));
    check(exp_q.size() == 0, "R9 all overlap words", 36'(exp_q.size()), 36'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule